// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This unit sits next to the fetch stage of a small signal-processing pipeline. It carries out a repeat instruction. A repeat can re-run one instruction, or a contiguous block of instructions, a programmed number of times. The unit tracks iterations in its own down-counter. While a loop is running, it steers the fetch address back to the loop start each time fetch reaches the last address of the loop body. No branch enters the instruction stream, so the only cost is the single flush taken when the repeat is set up.

The decoder presents the request with its mode, its count and the body bounds. Fetch presents the address it is fetching, together with a qualifier that is high when that fetch really advances. The unit returns:
- a redirect strobe with a target address,
- a loop-active flag,
- the number of repetitions still owed,
- an error strobe for a request that arrives while a loop is already running.

Top module: `zrl_loop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `loop_active` is 0, `remaining` is 0, and neither `redirect` nor `rpt_err` is asserted.
- R2: A request (`rpt_valid`=1) taken while no loop is active, with `rpt_count` N ≥ 2, sets `loop_active` to 1 and `remaining` to N-1 from the next clock edge.
- R3: While a loop is active, a cycle with `fetch_en`=1 and `fetch_pc` equal to the captured end address raises `redirect` in that same cycle, with `redirect_pc` equal to the captured start address.
- R4: Each cycle in which `redirect` is high lowers `remaining` by exactly one at the next edge.
- R5: A loop set up with count N issues exactly N-1 redirects. When `remaining` reaches 0, `loop_active` drops at the same edge, and the next fetch of the end address gets no redirect, so fetch continues sequentially.
- R6: `rpt_mode` 0 selects single-instruction mode. In that mode the end address is taken equal to `rpt_start`, `rpt_end` is ignored, and the one instruction at `rpt_start` runs N times in total. `rpt_mode` 1 selects block mode, with the body running from `rpt_start` to `rpt_end`.
- R7: A request with `rpt_count` of 0 or 1 starts no loop: `loop_active` stays 0 and no redirect follows.
- R8: A request that arrives while a loop is active is ignored: the count and the bounds are unchanged. `rpt_err` is high in that same cycle.
- R9: No redirect occurs, and `remaining` holds, in any cycle where `fetch_en` is 0 or `fetch_pc` differs from the end address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rpt_valid | input | 1 | Decoded repeat request |
| rpt_mode | input | 1 | 0 = single instruction, 1 = block |
| rpt_count | input | CW | Total executions requested |
| rpt_start | input | AW | First address of the loop body |
| rpt_end | input | AW | Last address of the body (block mode only) |
| fetch_pc | input | AW | Address being fetched this cycle |
| fetch_en | input | 1 | Fetch advances this cycle |
| redirect | output | 1 | Override the next fetch address |
| redirect_pc | output | AW | Override target (loop start) |
| loop_active | output | 1 | A loop is running |
| remaining | output | CW | Repetitions still owed |
| rpt_err | output | 1 | Request refused because a loop is active |

## Verification
`redirect`, `redirect_pc` and `rpt_err` are combinational from the current inputs and state, so they are due in the same cycle as the stimulus. The bench samples them a short delay after driving its inputs on the falling edge. `loop_active` and `remaining` change at the following rising edge, so the bench compares them at the next falling edge against a model. That model is stepped once per cycle with the same inputs. The bench also counts redirects per loop and compares the total with the programmed count minus one.

// File: rtl/zrl_pkg.sv
// Package: shared encodings for the repeat loop controller.
// Assumes: rpt_mode is a single bit driven by the decoder.
package zrl_pkg;
    typedef enum logic {
        RPT_SINGLE = 1'b0,
        RPT_BLOCK  = 1'b1
    } rpt_mode_e;

    localparam int unsigned MIN_LOOP_COUNT = 2;
endpackage

// File: rtl/zrl_iter_counter.sv
// Iteration down-counter. On load it takes the number of extra passes. On
// each decrement it drops by one, and active clears when the count hits zero.
// Assumes: load and dec are never high together (the top guarantees this).
module zrl_iter_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          active
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Count register: load, decrement or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (dec)    cnt <= cnt - ONE;
    end

    // Active flag: set on load, cleared at the last decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active <= 1'b0;
        else if (load)                active <= 1'b1;
        else if (dec && (cnt == ONE)) active <= 1'b0;
    end

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt == $past(cnt) - ONE));

    p_active_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active == (cnt != '0));
endmodule

// File: rtl/zrl_bounds.sv
// Loop bounds store. It captures the start and end addresses of the body and
// compares the fetch address with the end address.
// Assumes: in single mode the body is the one word at the start address.
module zrl_bounds #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          single,
    input  logic [AW-1:0] start_in,
    input  logic [AW-1:0] end_in,
    input  logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] start_q,
    output logic          at_end
);
    logic [AW-1:0] end_q;

    // Bounds registers: capture on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (capture) begin
            start_q <= start_in;
            end_q   <= single ? start_in : end_in;
        end
    end

    // End compare for the fetch address.
    always_comb at_end = (fetch_pc == end_q);

    p_single_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && single) |=> (start_q == end_q));

    p_hold_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(start_q) && $stable(end_q)));
endmodule

// File: rtl/zrl_loop_ctrl.sv
// Zero-overhead repeat loop controller: the top level. It accepts a repeat
// request when idle, redirects fetch to the body start at the body end while
// repetitions remain, and refuses requests that arrive during a loop.
// Assumes: no nesting and no interrupts. Fetch obeys redirect on the next
// fetch.
module zrl_loop_ctrl
    import zrl_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rpt_valid,
    input  logic          rpt_mode,
    input  logic [CW-1:0] rpt_count,
    input  logic [AW-1:0] rpt_start,
    input  logic [AW-1:0] rpt_end,
    input  logic [AW-1:0] fetch_pc,
    input  logic          fetch_en,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic          loop_active,
    output logic [CW-1:0] remaining,
    output logic          rpt_err
);
    localparam logic [CW-1:0] MIN_CNT = CW'(MIN_LOOP_COUNT);

    logic accept;
    logic at_end;
    logic single;

    // Request decode: accept only when idle and more than one pass is asked.
    always_comb begin
        single   = (rpt_mode_e'(rpt_mode) == RPT_SINGLE);
        accept   = rpt_valid && !loop_active && (rpt_count >= MIN_CNT);
        rpt_err  = rpt_valid && loop_active;
        redirect = loop_active && fetch_en && at_end;
    end

    zrl_bounds #(.AW(AW)) u_bounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept),
        .single   (single),
        .start_in (rpt_start),
        .end_in   (rpt_end),
        .fetch_pc (fetch_pc),
        .start_q  (redirect_pc),
        .at_end   (at_end)
    );

    zrl_iter_counter #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (rpt_count - CW'(1)),
        .dec      (redirect),
        .cnt      (remaining),
        .active   (loop_active)
    );

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !loop_active && (rpt_count >= MIN_CNT))
        |=> (loop_active && (remaining == $past(rpt_count) - CW'(1))));

    p_small_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !loop_active && (rpt_count < MIN_CNT)) |=> !loop_active);

    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && loop_active && !redirect) |=> (remaining == $past(remaining)));

    p_no_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !rpt_valid) |=> (remaining == $past(remaining)));
endmodule

// File: tb/zrl_loop_ctrl_bench.sv
module zrl_loop_ctrl_bench;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rpt_valid = 1'b0;
    logic          rpt_mode = 1'b0;
    logic [CW-1:0] rpt_count = '0;
    logic [AW-1:0] rpt_start = '0;
    logic [AW-1:0] rpt_end = '0;
    logic [AW-1:0] fetch_pc = '0;
    logic          fetch_en = 1'b0;
    logic          redirect;
    logic [AW-1:0] redirect_pc;
    logic          loop_active;
    logic [CW-1:0] remaining;
    logic          rpt_err;

    int checks = 0;
    int failures = 0;

    // Bench model state.
    bit m_act = 0;
    int m_cnt = 0;
    int m_start = 0;
    int m_end = 0;
    int pc = 0;
    int redirs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zrl_loop_ctrl #(.AW(AW), .CW(CW)) u_zrl_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_mode(rpt_mode),
        .rpt_count(rpt_count), .rpt_start(rpt_start), .rpt_end(rpt_end),
        .fetch_pc(fetch_pc), .fetch_en(fetch_en), .redirect(redirect),
        .redirect_pc(redirect_pc), .loop_active(loop_active),
        .remaining(remaining), .rpt_err(rpt_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_redirects(input int n);
        return (n >= 2) ? n - 1 : 0;
    endfunction

    // One clock: check registered state, drive, check combinational outputs, step model.
    task automatic cyc(input bit rv, input bit md, input int cnt, input int s,
                       input int e, input bit fen);
        bit exp_rd;
        bit exp_err;
        @(negedge clk);
        chk(loop_active == m_act, "R5 loop_active", int'(loop_active), int'(m_act));
        chk(int'(remaining) == m_cnt, "R4 remaining", int'(remaining), m_cnt);
        rpt_valid = rv; rpt_mode = md; rpt_count = CW'(cnt);
        rpt_start = AW'(s); rpt_end = AW'(e);
        fetch_en = fen; fetch_pc = AW'(pc);
        #1;
        exp_rd  = m_act && fen && (pc == m_end);
        exp_err = rv && m_act;
        chk(redirect == exp_rd, "R3/R9 redirect", int'(redirect), int'(exp_rd));
        if (exp_rd)
            chk(int'(redirect_pc) == m_start, "R3 redirect_pc", int'(redirect_pc), m_start);
        chk(rpt_err == exp_err, "R8 rpt_err", int'(rpt_err), int'(exp_err));
        if (redirect) redirs++;
        if (m_act) begin
            if (exp_rd) begin
                m_cnt--;
                if (m_cnt == 0) m_act = 0;
            end
        end else if (rv && cnt >= 2) begin
            m_act = 1; m_cnt = cnt - 1; m_start = s;
            m_end = md ? e : s;
        end
        if (fen) pc = exp_rd ? m_start : pc + 1;
    endtask

    // Issue one repeat and run fetch until the loop is over.
    task automatic run_loop(input bit md, input int cnt, input int s, input int e,
                            input bit inject);
        int last;
        last = md ? e : s;
        pc = s - 1;
        cyc(1, md, cnt, s, e, 1);
        redirs = 0;
        for (int n = 0; n < 4000; n++) begin
            if (!m_act && pc > last) break;
            if (inject && m_act && ($urandom_range(0, 5) == 0))
                cyc(1, $urandom_range(0, 1), $urandom_range(2, 9),
                    $urandom_range(0, 500), $urandom_range(0, 500),
                    $urandom_range(0, 4) != 0);
            else
                cyc(0, 0, 0, 0, 0, $urandom_range(0, 4) != 0);
        end
        chk(redirs == exp_redirects(cnt), "R5 redirect total", redirs, exp_redirects(cnt));
        chk(loop_active == 1'b0, "R5 finished", int'(loop_active), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(loop_active == 1'b0, "R1 active", int'(loop_active), 0);
        chk(remaining == '0, "R1 remaining", int'(remaining), 0);
        chk(redirect == 1'b0, "R1 redirect", int'(redirect), 0);
        chk(rpt_err == 1'b0, "R1 err", int'(rpt_err), 0);

        // R7: count 0 and 1 start nothing.
        run_loop(1, 0, 20, 23, 0);
        run_loop(1, 1, 20, 23, 0);
        run_loop(0, 1, 40, 40, 0);
        chk(loop_active == 1'b0, "R7 idle", int'(loop_active), 0);

        // R2: load value visible one edge later.
        pc = 99;
        cyc(1, 1, 4, 100, 102, 0);
        @(negedge clk);
        chk(int'(remaining) == 3, "R2 load", int'(remaining), 3);
        chk(loop_active == 1'b1, "R2 active", int'(loop_active), 1);
        // R9: fetch stalled at end address -> no redirect, count holds.
        pc = 102;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk(int'(remaining) == 3, "R9 hold", int'(remaining), 3);
        // R8: request while busy is refused.
        pc = 100;
        cyc(1, 1, 7, 300, 310, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk(int'(remaining) == 3, "R8 count kept", int'(remaining), 3);
        redirs = 0;
        for (int n = 0; n < 40; n++) begin
            if (!m_act && pc > 102) break;
            cyc(0, 0, 0, 0, 0, 1);
        end
        chk(redirs == 3, "R5 directed total", redirs, 3);

        // R6: single mode ignores rpt_end; R5 boundary with large count.
        run_loop(0, 5, 60, 90, 0);
        run_loop(0, 2, 70, 70, 0);
        run_loop(1, 2, 80, 80, 0);
        run_loop(0, 255, 200, 3, 0);

        // Random mix with busy-time requests.
        for (int i = 0; i < 60; i++) begin
            int s;
            s = $urandom_range(10, 1000);
            run_loop($urandom_range(0, 1), $urandom_range(0, 9), s,
                     s + $urandom_range(0, 4), 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule